// File: doc/BRIEF.md
# Packed Dual Half-Word Multiply-Accumulate

This block treats each 32-bit operand as two signed 16-bit lanes. In one operation it multiplies the upper lane of the first operand by the upper lane of the second operand, and the lower lane by the lower lane. It then combines the two products by addition or by subtraction, and adds the result to an accumulator input. Optionally, the halves of the second operand are swapped before the multiplies.

The accumulation runs either at 64 bits, or at 32 bits with a sticky flag for signed overflow. In the default registered variant, an operation is accepted on every cycle that carries a valid strobe, and its result appears one cycle later.

The result can be routed straight back to the accumulator input. A string of issues then builds a dot product of packed vectors, for example a row of one matrix against a row of a transposed matrix. A vector with an odd number of elements is padded with a zero lane.

Top module: `pkd_mac`

## Requirements
- R1: While reset is held and in the first cycle after it, `out_vld`, `res` and `ovf_flag` are all zero.
- R2: With `sub_en=0`, `xchg_en=0` and `wide_en=1`, the result is `acc_in + sA_hi*sB_hi + sA_lo*sB_lo` modulo 2^64. Here hi means bits [31:16] and lo means bits [15:0], and both lanes are read as signed.
- R3: With `sub_en=1`, the upper-lane product minus the lower-lane product is added to the accumulator instead of their sum.
- R4: With `xchg_en=1`, the two halves of `op_b` are swapped before multiplying, so the products are `sA_hi*sB_lo` and `sA_lo*sB_hi`.
- R5: With `wide_en=0`, only `acc_in[31:0]` (signed) is used. The sum wraps modulo 2^32, and `res[63:32]` is a copy of `res[31]`.
- R6: A valid operation with `wide_en=0` whose exact sum lies outside [-2^31, 2^31-1] sets `ovf_flag` at the same edge that registers the result.
- R7: `ovf_flag` stays set until `ovf_clr` is high at a clock edge. When a clear and a new overflowing operation meet at the same edge, the flag stays set.
- R8: A valid operation with `wide_en=1` never sets `ovf_flag`, whatever its magnitude.
- R9: In the registered variant, `out_vld` equals `in_vld` delayed by one cycle, and `res` holds its value after any cycle in which `in_vld` was low.
- R10: When `res` is fed back to `acc_in` on back-to-back valid cycles, the block produces the running dot product of the packed vectors, with zero-padded lanes adding nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Operation strobe |
| op_a | input | 32 | First packed operand, two signed lanes |
| op_b | input | 32 | Second packed operand, two signed lanes |
| acc_in | input | 64 | Accumulator addend; only [31:0] is used in 32-bit mode |
| sub_en | input | 1 | Combine products as upper minus lower |
| xchg_en | input | 1 | Swap the halves of `op_b` |
| wide_en | input | 1 | 64-bit accumulate when high, 32-bit when low |
| ovf_clr | input | 1 | Clears the sticky overflow flag |
| out_vld | output | 1 | Result strobe |
| res | output | 64 | Accumulated result |
| ovf_flag | output | 1 | Sticky signed-overflow flag for 32-bit mode |

## Verification
The overflow flag has two update sources, a clear request and a newly detected overflow, and both can arrive at the same clock edge. The bench provokes this by raising `ovf_clr` in the same cycle as a 32-bit operation whose exact sum exceeds 2^31-1. It then expects the flag to read high one cycle later. A following cycle with only the clear active must bring the flag low, and a later wide operation of large magnitude must leave it low.

// File: rtl/pkd_mac_pkg.sv
package pkd_mac_pkg;

    // How the two lane products are merged before accumulation
    typedef enum logic {
        CMB_ADD = 1'b0,
        CMB_SUB = 1'b1
    } cmb_e;

    // Number of lanes packed in one operand word
    localparam int unsigned N_LANES = 2;

endpackage

// File: rtl/pkd_mac_lanes.sv
module pkd_mac_lanes
    import pkd_mac_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned WORD_W = N_LANES * LANE_W,
    localparam int unsigned PROD_W = 2 * LANE_W
) (
    input  logic [WORD_W-1:0]              op_a,
    input  logic [WORD_W-1:0]              op_b,
    input  logic                           xchg_en,
    output logic signed [N_LANES-1:0][PROD_W-1:0] prod
);

    // One signed multiplier per lane; lane g of op_a meets lane g
    // (or the opposite lane when exchanging) of op_b.
    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam int unsigned OPP = N_LANES - 1 - g;
        logic signed [LANE_W-1:0] a_l;
        logic signed [LANE_W-1:0] b_l;

        always_comb begin
            a_l = op_a[g*LANE_W +: LANE_W];
            b_l = xchg_en ? op_b[OPP*LANE_W +: LANE_W] : op_b[g*LANE_W +: LANE_W];
            prod[g] = PROD_W'(a_l * b_l);
        end
    end

endmodule

// File: rtl/pkd_mac_sum.sv
module pkd_mac_sum
    import pkd_mac_pkg::*;
#(
    parameter int unsigned LANE_W = 16,
    localparam int unsigned WORD_W = N_LANES * LANE_W,
    localparam int unsigned PROD_W = 2 * LANE_W,
    localparam int unsigned ACC_W  = 2 * WORD_W,
    localparam int unsigned CMB_W  = PROD_W + 1,
    localparam int unsigned NRW_W  = WORD_W + 2
) (
    input  logic signed [PROD_W-1:0] p_hi,
    input  logic signed [PROD_W-1:0] p_lo,
    input  logic [ACC_W-1:0]         acc_in,
    input  cmb_e                     cmb,
    input  logic                     wide_en,
    output logic [ACC_W-1:0]         sum,
    output logic                     ovf
);

    logic signed [CMB_W-1:0] pair_d;
    logic signed [ACC_W-1:0] wide_sum;
    logic signed [NRW_W-1:0] nrw_sum;
    logic signed [WORD_W-1:0] acc_lo;

    always_comb begin
        // Merge lane products with one spare bit so nothing is lost
        if (cmb == CMB_SUB) begin
            pair_d = CMB_W'(p_hi) - CMB_W'(p_lo);
        end else begin
            pair_d = CMB_W'(p_hi) + CMB_W'(p_lo);
        end

        acc_lo   = acc_in[WORD_W-1:0];
        wide_sum = $signed(acc_in) + ACC_W'(pair_d);
        nrw_sum  = NRW_W'(acc_lo) + NRW_W'(pair_d);

        if (wide_en) begin
            sum = wide_sum;
            ovf = 1'b0;
        end else begin
            sum = {{(ACC_W-WORD_W){nrw_sum[WORD_W-1]}}, nrw_sum[WORD_W-1:0]};
            // Exact value fits only if the top three bits agree
            ovf = !((nrw_sum[NRW_W-1:WORD_W-1] == '0) || (nrw_sum[NRW_W-1:WORD_W-1] == '1));
        end
    end

endmodule

// File: rtl/pkd_mac.sv
module pkd_mac
    import pkd_mac_pkg::*;
#(
    parameter int unsigned LANE_W  = 16,
    parameter bit          REG_OUT = 1'b1,
    localparam int unsigned WORD_W = N_LANES * LANE_W,
    localparam int unsigned PROD_W = 2 * LANE_W,
    localparam int unsigned ACC_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [WORD_W-1:0] op_a,
    input  logic [WORD_W-1:0] op_b,
    input  logic [ACC_W-1:0]  acc_in,
    input  logic              sub_en,
    input  logic              xchg_en,
    input  logic              wide_en,
    input  logic              ovf_clr,
    output logic              out_vld,
    output logic [ACC_W-1:0]  res,
    output logic              ovf_flag
);

    typedef struct packed {
        logic             vld;
        logic [ACC_W-1:0] res;
        logic             ovf;
    } state_t;

    state_t st_d, st_q;

    logic signed [N_LANES-1:0][PROD_W-1:0] prod;
    logic [ACC_W-1:0] sum_res;
    logic             sum_ovf;
    cmb_e             cmb;

    assign cmb = sub_en ? CMB_SUB : CMB_ADD;

    pkd_mac_lanes #(.LANE_W(LANE_W)) u_lanes (
        .op_a    (op_a),
        .op_b    (op_b),
        .xchg_en (xchg_en),
        .prod    (prod)
    );

    pkd_mac_sum #(.LANE_W(LANE_W)) u_sum (
        .p_hi    (prod[1]),
        .p_lo    (prod[0]),
        .acc_in  (acc_in),
        .cmb     (cmb),
        .wide_en (wide_en),
        .sum     (sum_res),
        .ovf     (sum_ovf)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_vld;
        if (in_vld) begin
            st_d.res = sum_res;
        end
        // A fresh overflow outranks a clear at the same edge
        st_d.ovf = (st_q.ovf & ~ovf_clr) | (in_vld & sum_ovf);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ovf_flag = st_q.ovf;

    // Cycles since reset: guards properties that look one cycle back
    logic chk_arm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_arm_q <= 1'b0;
        end else begin
            chk_arm_q <= 1'b1;
        end
    end

    if (REG_OUT) begin : g_reg
        assign out_vld = st_q.vld;
        assign res     = st_q.res;

        p_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
            chk_arm_q |-> (out_vld == $past(in_vld)));

        p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (chk_arm_q && !$past(in_vld)) |-> $stable(res));
    end else begin : g_comb
        assign out_vld = in_vld;
        assign res     = sum_res;
    end

    p_ovf_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm_q && $past(in_vld && sum_ovf)) |-> ovf_flag);

    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm_q && $past(ovf_flag) && !$past(ovf_clr)) |-> ovf_flag);

    p_wide_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_arm_q && $past(!ovf_flag && (!in_vld || wide_en))) |-> !ovf_flag);

endmodule

// File: tb/sim_pkd_mac.sv
`timescale 1ns/1ps
module sim_pkd_mac;

    localparam time T_CLK = 8ns;

    typedef struct packed {
        logic [31:0] a;
        logic [31:0] b;
        logic [63:0] acc;
        logic        sub;
        logic        xchg;
        logic        wide;
    } vec_t;

    localparam int N_VEC = 8;
    localparam vec_t VECS [N_VEC] = '{
        '{32'h0003_0004, 32'h0005_0006, 64'd10,                  1'b0, 1'b0, 1'b1},
        '{32'hFFFF_8000, 32'h0002_8000, 64'd0,                   1'b1, 1'b0, 1'b0},
        '{32'h0003_0004, 32'h0005_0006, 64'd0,                   1'b0, 1'b1, 1'b1},
        '{32'h0003_0004, 32'h0005_0006, 64'd0,                   1'b1, 1'b1, 1'b0},
        '{32'h8000_8000, 32'h8000_8000, 64'h0000_0000_7FFF_FFFF, 1'b0, 1'b0, 1'b0},
        '{32'h8000_8000, 32'h8000_8000, 64'h7FFF_FFFF_FFFF_FFFF, 1'b0, 1'b0, 1'b1},
        '{32'h7FFF_8000, 32'h8000_7FFF, 64'hFFFF_FFFF_8000_0000, 1'b1, 1'b0, 1'b0},
        '{32'h8000_0001, 32'h7FFF_FFFF, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [31:0] op_a = '0;
    logic [31:0] op_b = '0;
    logic [63:0] acc_in = '0;
    logic        sub_en = 1'b0;
    logic        xchg_en = 1'b0;
    logic        wide_en = 1'b0;
    logic        ovf_clr = 1'b0;
    logic        out_vld;
    logic [63:0] res;
    logic        ovf_flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(T_CLK/2) clk = ~clk;

    pkd_mac u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .op_a(op_a), .op_b(op_b),
        .acc_in(acc_in), .sub_en(sub_en), .xchg_en(xchg_en), .wide_en(wide_en),
        .ovf_clr(ovf_clr), .out_vld(out_vld), .res(res), .ovf_flag(ovf_flag)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Reference built from the requirement text
    function automatic void model(input vec_t v, output logic [63:0] r, output logic o);
        logic [15:0] bh, bl;
        longint p, q, c, s;
        bh = v.xchg ? v.b[15:0]  : v.b[31:16];
        bl = v.xchg ? v.b[31:16] : v.b[15:0];
        p = longint'($signed(v.a[31:16])) * longint'($signed(bh));
        q = longint'($signed(v.a[15:0]))  * longint'($signed(bl));
        c = v.sub ? p - q : p + q;
        if (v.wide) begin
            r = v.acc + 64'(c);
            o = 1'b0;
        end else begin
            s = longint'($signed(v.acc[31:0])) + c;
            o = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            r = {{32{s[31]}}, s[31:0]};
        end
    endfunction

    task automatic drive(input vec_t v);
        op_a = v.a; op_b = v.b; acc_in = v.acc;
        sub_en = v.sub; xchg_en = v.xchg; wide_en = v.wide;
        in_vld = 1'b1;
    endtask

    initial begin
        logic [63:0] r_exp;
        logic        o_exp;
        logic        flg_exp;
        logic [63:0] held;
        vec_t        w;

        flg_exp = 1'b0;
        repeat (3) @(negedge clk);
        // R1: state under reset
        check("R1 out_vld in reset", 64'(out_vld), 64'd0);
        check("R1 res in reset", res, 64'd0);
        check("R1 ovf_flag in reset", 64'(ovf_flag), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 res after reset", res, 64'd0);

        // Table walk: R2..R6 by mode bits
        for (int i = 0; i < N_VEC; i++) begin
            string tag;
            tag = VECS[i].sub ? "R3" : (VECS[i].xchg ? "R4" : (VECS[i].wide ? "R2" : "R5"));
            drive(VECS[i]);
            model(VECS[i], r_exp, o_exp);
            flg_exp = flg_exp | o_exp;
            @(negedge clk);
            in_vld = 1'b0;
            check($sformatf("%s vector %0d res", tag, i), res, r_exp);
            check($sformatf("R9 vector %0d out_vld", i), 64'(out_vld), 64'd1);
            check($sformatf("R6 vector %0d ovf_flag", i), 64'(ovf_flag), 64'(flg_exp));
        end

        // R9: no strobe -> result holds, out_vld drops
        held = res;
        op_a = 32'h1234_5678; op_b = 32'h7654_3210; acc_in = 64'hDEAD_BEEF_0000_0001;
        @(negedge clk);
        check("R9 out_vld low after idle", 64'(out_vld), 64'd0);
        check("R9 res held when idle", res, held);
        @(negedge clk);
        check("R9 res still held", res, held);

        // R7: clear alone drops the flag
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R7 flag cleared", 64'(ovf_flag), 64'd0);

        // R10: running dot product [1,2,3] . [4,5,6] padded to four lanes
        w = '{32'h0001_0002, 32'h0004_0005, 64'd0, 1'b0, 1'b0, 1'b1};
        drive(w);
        @(negedge clk);
        w = '{32'h0003_0000, 32'h0006_0000, res, 1'b0, 1'b0, 1'b1};
        drive(w);
        @(negedge clk);
        in_vld = 1'b0;
        check("R10 running dot product", res, 64'd32);
        check("R10 out_vld back to back", 64'(out_vld), 64'd1);

        // R7: clear meets a fresh narrow overflow at the same edge
        drive(VECS[4]);
        ovf_clr = 1'b1;
        @(negedge clk);
        in_vld = 1'b0;
        check("R7 set wins over clear", 64'(ovf_flag), 64'd1);
        @(negedge clk);
        ovf_clr = 1'b0;
        check("R7 clear after collision", 64'(ovf_flag), 64'd0);

        // R8: large wide operation leaves the flag alone
        drive(VECS[5]);
        @(negedge clk);
        in_vld = 1'b0;
        model(VECS[5], r_exp, o_exp);
        check("R8 wide result", res, r_exp);
        check("R8 wide leaves flag low", 64'(ovf_flag), 64'd0);

        // R6: negative narrow overflow raises the flag again
        drive(VECS[7]);
        @(negedge clk);
        in_vld = 1'b0;
        check("R6 negative overflow sets flag", 64'(ovf_flag), 64'd1);
        @(negedge clk);
        check("R7 flag sticky while idle", 64'(ovf_flag), 64'd1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(T_CLK * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule